// File: doc/BRIEF.md
# Video Sync and Blank Conditioning Path

This block conditions the horizontal sync, vertical sync and blank signals that go with a pixel stream. It accepts two complete sets of timing inputs: a high-resolution system set, whose syncs are active-low pulses, and a legacy VGA set, whose syncs already carry the polarity the monitor expects. A mode bit selects the active set. Each set is captured on its own clock edge: a falling edge of the system video clock or a rising edge of the VGA clock. The captured signals are then carried through a fixed-depth pipeline in the pixel clock domain, so they reach the outputs in step with pixel data that has the same depth.

In system mode, each sync passes through a true/complement stage that a polarity bit controls. In VGA mode the syncs pass through as they arrive. Blank never gates the syncs. The design is a single-clock model. The pixel clock `clk` samples both source clocks as data, and edge detectors turn their edges into capture enables.

Top module: `vidsync_cond`

## Requirements
- R1: Writing `muxWrData` with `muxWrEn` high stores bit 7 as the mode bit. A 1 selects the VGA input set and VGA clock, and a 0 selects the system set and system clock. The mode bit resets to 0.
- R2: In system mode, the system sync and blank inputs are captured only on a falling edge of `sysClk` (high on one pixel clock, low on the next). A rising edge or a steady level captures nothing.
- R3: In VGA mode, the VGA inputs are captured only on a rising edge of `vgaClk`. A falling edge captures nothing.
- R4: Inputs of the set that is not selected, and edges of its clock, have no effect on the outputs.
- R5: Writing `ctlWrData` with `ctlWrEn` high stores bit 0 as the horizontal polarity bit and bit 1 as the vertical polarity bit. Both reset to 0. In system mode, an output equals its captured active-low input when its bit is 0, and the complement of that input when its bit is 1.
- R6: In VGA mode, the VGA sync inputs reach the outputs unchanged, whatever the polarity bits hold.
- R7: A capture on pixel clock edge k appears on all three outputs at edge k+1+PIPE_DEPTH. Blank passes through one resampling register in the pixel domain and then PIPE_DEPTH stages, and both syncs pass through the same number of registers.
- R8: An active sync reaches its output whether blank is active or not.
- R9: While `rstN` is low, `hSyncOut` and `vSyncOut` are 1 and `blankOut` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rstN | input | 1 | Active-low synchronous reset |
| muxWrEn | input | 1 | Write strobe for the mode register |
| muxWrData | input | 8 | Mode register data; bit 7 is the VGA select |
| ctlWrEn | input | 1 | Write strobe for the polarity register |
| ctlWrData | input | 8 | Polarity data; bit 0 is horizontal, bit 1 is vertical |
| sysClk | input | 1 | System video clock, sampled as data |
| sysHsN | input | 1 | System horizontal sync, active low |
| sysVsN | input | 1 | System vertical sync, active low |
| sysBlank | input | 1 | System blank, active high |
| vgaClk | input | 1 | VGA clock, sampled as data |
| vgaHs | input | 1 | VGA horizontal sync, monitor polarity |
| vgaVs | input | 1 | VGA vertical sync, monitor polarity |
| vgaBlank | input | 1 | VGA blank, active high |
| hSyncOut | output | 1 | Delayed horizontal sync |
| vSyncOut | output | 1 | Delayed vertical sync |
| blankOut | output | 1 | Delayed blank |

## Verification
Assertions check four things on every cycle:
- Each pipeline stage repeats the previous stage one clock later.
- A system capture stores the inputs that were present at the falling edge.
- A VGA capture strobe never fires in system mode.
- No polarity inversion reaches the datapath in VGA mode.

Only the bench scenarios can show end-to-end behaviour at the pins:
- the exact output latency, including that the outputs have not yet changed one cycle earlier;
- that the wrong clock edge, or the unselected input set, leaves the outputs alone;
- that polarity bits programmed earlier stop acting after a switch to VGA mode.

// File: rtl/vidsync_pkg.sv
package vidsync_pkg;

  typedef struct packed {
    logic capSys;
    logic capVga;
    logic selVga;
    logic invH;
    logic invV;
  } vsStrobe_t;

  typedef struct packed {
    logic hs;
    logic vs;
    logic bl;
  } vsBeat_t;

  localparam vsBeat_t BEAT_IDLE = '{hs: 1'b1, vs: 1'b1, bl: 1'b0};

endpackage

// File: rtl/vidsync_ctrl.sv
module vidsync_ctrl
  import vidsync_pkg::*;
#(
  parameter int REG_W    = 8,
  parameter int MODE_BIT = 7,
  parameter int HPOL_BIT = 0,
  parameter int VPOL_BIT = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             muxWrEn,
  input  logic [REG_W-1:0] muxWrData,
  input  logic             ctlWrEn,
  input  logic [REG_W-1:0] ctlWrData,
  input  logic             sysClk,
  input  logic             vgaClk,
  output vsStrobe_t        strobe
);

  logic modeVga, hPol, vPol;
  logic sysClkQ, vgaClkQ;
  logic sysFall, vgaRise;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeVga <= 1'b0;
      hPol    <= 1'b0;
      vPol    <= 1'b0;
      sysClkQ <= 1'b0;
      vgaClkQ <= 1'b0;
    end else begin
      if (muxWrEn) modeVga <= muxWrData[MODE_BIT];
      if (ctlWrEn) begin
        hPol <= ctlWrData[HPOL_BIT];
        vPol <= ctlWrData[VPOL_BIT];
      end
      sysClkQ <= sysClk;
      vgaClkQ <= vgaClk;
    end
  end

  assign sysFall = sysClkQ & ~sysClk;
  assign vgaRise = ~vgaClkQ & vgaClk;

  always_comb begin
    strobe.selVga = modeVga;
    strobe.capSys = sysFall & ~modeVga;
    strobe.capVga = vgaRise & modeVga;
    strobe.invH   = hPol & ~modeVga;
    strobe.invV   = vPol & ~modeVga;
  end

  // R2/R3: at most one capture source fires in any cycle
  p_one_capture_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.capSys, strobe.capVga}));

  // R1: the mode register takes bit MODE_BIT of a write
  p_mode_write_r1: assert property (@(posedge clk) disable iff (!rstN)
    muxWrEn |=> (strobe.selVga == $past(muxWrData[MODE_BIT])));

endmodule

// File: rtl/vidsync_dp.sv
module vidsync_dp
  import vidsync_pkg::*;
#(
  parameter int PIPE_DEPTH = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  vsStrobe_t strobe,
  input  logic      sysHsN,
  input  logic      sysVsN,
  input  logic      sysBlank,
  input  logic      vgaHs,
  input  logic      vgaVs,
  input  logic      vgaBlank,
  output vsBeat_t   beatOut
);

  vsBeat_t capQ;
  vsBeat_t stageIn;
  vsBeat_t alignQ;
  vsBeat_t pipeQ [PIPE_DEPTH+1];

  // capture register, source picked by the active strobe
  always_ff @(posedge clk) begin
    if (!rstN) begin
      capQ <= BEAT_IDLE;
    end else if (strobe.capSys) begin
      capQ <= '{hs: sysHsN, vs: sysVsN, bl: sysBlank};
    end else if (strobe.capVga) begin
      capQ <= '{hs: vgaHs, vs: vgaVs, bl: vgaBlank};
    end
  end

  // true/complement stage; blank never gates sync
  always_comb begin
    stageIn.hs = capQ.hs ^ strobe.invH;
    stageIn.vs = capQ.vs ^ strobe.invV;
    stageIn.bl = capQ.bl;
  end

  // pixel-domain resample, with syncs held in step
  always_ff @(posedge clk) begin
    if (!rstN) alignQ <= BEAT_IDLE;
    else       alignQ <= stageIn;
  end

  assign pipeQ[0] = alignQ;

  for (genvar i = 0; i < PIPE_DEPTH; i++) begin : gStage
    always_ff @(posedge clk) begin
      if (!rstN) pipeQ[i+1] <= BEAT_IDLE;
      else       pipeQ[i+1] <= pipeQ[i];
    end

    // R7: each stage carries its neighbour one clock later
    p_stage_shift_r7: assert property (@(posedge clk) disable iff (!rstN)
      pipeQ[i+1] == $past(pipeQ[i]));
  end

  assign beatOut = pipeQ[PIPE_DEPTH];

  // R2: a system capture stores the inputs seen at the falling edge
  p_sys_capture_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capSys |=> (capQ == $past({sysHsN, sysVsN, sysBlank})));

  // R3: the VGA capture strobe only fires in VGA mode
  p_vga_capture_mode_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capVga |-> strobe.selVga);

  // R6: no inversion reaches the datapath in VGA mode
  p_no_invert_vga_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.selVga |-> (!strobe.invH && !strobe.invV));

endmodule

// File: rtl/vidsync_cond.sv
module vidsync_cond
  import vidsync_pkg::*;
#(
  parameter int PIPE_DEPTH = 4,
  parameter int REG_W      = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             muxWrEn,
  input  logic [REG_W-1:0] muxWrData,
  input  logic             ctlWrEn,
  input  logic [REG_W-1:0] ctlWrData,
  input  logic             sysClk,
  input  logic             sysHsN,
  input  logic             sysVsN,
  input  logic             sysBlank,
  input  logic             vgaClk,
  input  logic             vgaHs,
  input  logic             vgaVs,
  input  logic             vgaBlank,
  output logic             hSyncOut,
  output logic             vSyncOut,
  output logic             blankOut
);

  vsStrobe_t strobe;
  vsBeat_t   beatOut;

  vidsync_ctrl #(.REG_W(REG_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .muxWrEn(muxWrEn), .muxWrData(muxWrData),
    .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .sysClk(sysClk), .vgaClk(vgaClk),
    .strobe(strobe)
  );

  vidsync_dp #(.PIPE_DEPTH(PIPE_DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .sysHsN(sysHsN), .sysVsN(sysVsN), .sysBlank(sysBlank),
    .vgaHs(vgaHs), .vgaVs(vgaVs), .vgaBlank(vgaBlank),
    .beatOut(beatOut)
  );

  assign hSyncOut = beatOut.hs;
  assign vSyncOut = beatOut.vs;
  assign blankOut = beatOut.bl;

endmodule

// File: tb/vidsync_cond_test.sv
module vidsync_cond_test;

  localparam int DEPTH = 4;
  localparam int LAT   = DEPTH + 2;  // negedges from driving the edge to output

  logic clk = 1'b0, rstN = 1'b0;
  logic muxWrEn = 1'b0, ctlWrEn = 1'b0;
  logic [7:0] muxWrData = '0, ctlWrData = '0;
  logic sysClk = 1'b1, sysHsN = 1'b1, sysVsN = 1'b1, sysBlank = 1'b0;
  logic vgaClk = 1'b0, vgaHs = 1'b0, vgaVs = 1'b0, vgaBlank = 1'b0;
  logic hSyncOut, vSyncOut, blankOut;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  vidsync_cond #(.PIPE_DEPTH(DEPTH)) uut (.*);

  task automatic check(string tag, logic [2:0] exp);
    checks++;
    if ({hSyncOut, vSyncOut, blankOut} !== exp) begin
      errors++;
      $display("FAIL %s actual h/v/b=%b expected %b", tag,
               {hSyncOut, vSyncOut, blankOut}, exp);
    end
  endtask

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeMux(logic [7:0] d);
    @(negedge clk); muxWrEn = 1'b1; muxWrData = d;
    @(negedge clk); muxWrEn = 1'b0;
  endtask

  task automatic writeCtl(logic [7:0] d);
    @(negedge clk); ctlWrEn = 1'b1; ctlWrData = d;
    @(negedge clk); ctlWrEn = 1'b0;
  endtask

  // present system inputs, then a falling edge of sysClk
  task automatic sysFall(logic h, logic v, logic b);
    @(negedge clk); sysHsN = h; sysVsN = v; sysBlank = b; sysClk = 1'b1;
    @(negedge clk); sysClk = 1'b0;
  endtask

  task automatic vgaRise(logic h, logic v, logic b);
    @(negedge clk); vgaHs = h; vgaVs = v; vgaBlank = b; vgaClk = 1'b0;
    @(negedge clk); vgaClk = 1'b1;
  endtask

  task automatic tReset();
    waitN(3);
    check("R9 outputs during reset", 3'b110);
    @(negedge clk); rstN = 1'b1;
    waitN(2);
    check("R9 outputs after reset release", 3'b110);
  endtask

  task automatic tSysLatency();
    sysFall(1'b0, 1'b1, 1'b1);
    waitN(LAT - 1);
    check("R7 no change one cycle early", 3'b110);
    waitN(1);
    check("R7 R5 default active-low, blank aligned", 3'b011);
  endtask

  task automatic tSysRisingIgnored();
    sysFall(1'b1, 1'b1, 1'b0);
    waitN(LAT);
    check("R2 falling edge capture", 3'b110);
    @(negedge clk); sysHsN = 1'b0; sysVsN = 1'b0; sysBlank = 1'b1;
    @(negedge clk); sysClk = 1'b1;
    waitN(LAT + 2);
    check("R2 rising edge ignored", 3'b110);
    @(negedge clk); sysClk = 1'b0;
    waitN(LAT);
    check("R2 next falling edge captures", 3'b001);
  endtask

  task automatic tPolarity();
    writeCtl(8'h01);
    sysFall(1'b0, 1'b0, 1'b1);
    waitN(LAT);
    check("R5 horizontal inverted only", 3'b101);
    writeCtl(8'h03);
    sysFall(1'b1, 1'b0, 1'b1);
    waitN(LAT);
    check("R5 both inverted", 3'b011);
  endtask

  task automatic tNotGated();
    writeCtl(8'h00);
    sysFall(1'b0, 1'b0, 1'b0);
    waitN(LAT);
    check("R8 sync active while blank inactive", 3'b000);
  endtask

  task automatic tVga();
    writeCtl(8'h03);
    writeMux(8'h80);
    vgaRise(1'b1, 1'b0, 1'b1);
    waitN(LAT);
    check("R1 R3 R6 VGA pass-through", 3'b101);
    sysFall(1'b0, 1'b1, 1'b0);
    waitN(LAT);
    check("R4 system inputs ignored in VGA mode", 3'b101);
    @(negedge clk); vgaHs = 1'b0; vgaVs = 1'b1; vgaBlank = 1'b0;
    @(negedge clk); vgaClk = 1'b0;
    waitN(LAT + 2);
    check("R3 VGA falling edge ignored", 3'b101);
    @(negedge clk); vgaClk = 1'b1;
    waitN(LAT);
    check("R3 R6 VGA next rising edge", 3'b010);
  endtask

  task automatic tBackToSys();
    writeMux(8'h7F);
    vgaRise(1'b1, 1'b1, 1'b1);
    sysFall(1'b0, 1'b1, 1'b0);
    waitN(LAT);
    check("R1 R4 R5 system mode again, VGA ignored", 3'b100);
  endtask

  initial begin
    tReset();
    tSysLatency();
    tSysRisingIgnored();
    tPolarity();
    tNotGated();
    tVga();
    tBackToSys();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule